// File: doc/BRIEF.md
# Alarm-Driven Power-Off Controller

This block is a second time-match alarm that sits beside a running calendar clock. It keeps six packed-BCD alarm fields: seconds, minutes, hours, day, month and year. Each time the clock's seconds value changes, it compares them with the live time. When the alarm is armed and all six fields are equal, it raises a sticky status flag. If pin control is also enabled, it switches an external power-enable output to its OFF level, so that an off-board power-management device can shut the system down.

Software reaches the block through a small register port that accepts byte or word writes. The port covers the six alarm fields, a 32-bit power-control word, and the shared status and interrupt-enable words. Reads are combinational from the address. A typical shutdown sequence runs in four steps:

- Enable pin control with a word write.
- Load the alarm with a time at least two seconds in the future, because a value equal to the current second may never see a seconds change.
- Arm the alarm with a word write to the interrupt-enable word.
- Wait for the system to lose power.

The output is driven by a two-state machine:

- PWR_ON is the reset state. power_en is 1.
- PWR_OFF drives power_en to 0.
- The only transition is SHUTDOWN, from PWR_ON to PWR_OFF. It is taken on a match event while pin control is enabled.
- PWR_OFF holds until reset. Nothing else leaves it.

Top module: `rtc_pwroff_ctrl`

## Requirements
- R1: After reset, power_en is 1, and reads of status (0x44), interrupt enable (0x48), power control (0x98) and every alarm field return 0.
- R2: The alarm fields sit at 0x80 (seconds), 0x84 (minutes), 0x88 (hours), 0x8C (day), 0x90 (month) and 0x94 (year). A byte or word write stores wdata[7:0]. A read returns that byte in bits 7:0, with bits 31:8 reading 0.
- R3: Power-control bit 16 (0x98) is written only by a word write (reg_word=1). A byte write leaves it unchanged. It reads back in bit 16.
- R4: Interrupt-enable bit 4 (0x48) arms the alarm. Only a word write changes it, and a byte write leaves it unchanged. A word write of 0 disarms the alarm.
- R5: A match event occurs in a cycle in which three things hold: the alarm is armed, all six fields equal the time bus, and tm_sec differs from its value in the previous cycle. The event sets status bit 7 (0x44) at the next clock edge. A mismatch in any one field gives no event.
- R6: No event occurs while the alarm is disarmed. No event occurs while tm_sec is steady, even if the fields match. One seconds change gives at most one event.
- R7: Writing a 1 to status bit 7 clears the flag, and writing 0 to that bit leaves it set. If a clear and a match event fall in the same cycle, the flag ends up set.
- R8: With power-control bit 16 set, power_en goes to 0 at the clock edge that ends the event cycle.
- R9: With power-control bit 16 clear, a match event still sets status bit 7 and leaves power_en at 1.
- R10: Once power_en is 0, it stays 0 until reset. Clearing the status flag, disarming the alarm or clearing bit 16 does not bring it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tm_sec | input | 8 | Current seconds, BCD |
| tm_min | input | 8 | Current minutes, BCD |
| tm_hour | input | 8 | Current hours, BCD |
| tm_day | input | 8 | Current day of month, BCD |
| tm_mon | input | 8 | Current month, BCD |
| tm_year | input | 8 | Current year, BCD |
| reg_wr | input | 1 | Register write strobe |
| reg_word | input | 1 | 1 = word (32-bit) write, 0 = byte write |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| power_en | output | 1 | External power enable, 1 = ON |

## Verification
Two functions can meet in one cycle: a software clear of the status flag, and a match event that sets it. The bench provokes this by driving a write of 0x80 to 0x44 in the same cycle that it steps tm_sec onto an armed alarm with pin control enabled. It then expects the flag to read set and power_en to read 0 in the next cycle. A second overlap, an alarm field rewritten to the current second while tm_sec is steady, is judged by confirming that the status flag stays clear.

// File: rtl/rtc_pwroff_pkg.sv
package rtc_pwroff_pkg;
    localparam int NUM_FIELDS     = 6;      // sec, min, hour, day, month, year
    localparam int FIELD_W        = 8;      // packed BCD
    localparam int OFS_STATUS     = 'h44;
    localparam int OFS_IRQ_EN     = 'h48;
    localparam int OFS_ALARM_BASE = 'h80;   // field i at base + 4*i
    localparam int OFS_PWR_CTL    = 'h98;
    localparam int STS_BIT        = 7;
    localparam int ARM_BIT        = 4;
    localparam int CTL_BIT        = 16;

    typedef enum logic {
        PWR_ON  = 1'b0,
        PWR_OFF = 1'b1
    } pwr_state_e;
endpackage

// File: rtl/rtc_pwroff_regs.sv
module rtc_pwroff_regs
    import rtc_pwroff_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic                                wr_word,
    input  logic [ADDR_W-1:0]                   addr,
    input  logic [DATA_W-1:0]                   wdata,
    input  logic                                evt,
    output logic [NUM_FIELDS-1:0][FIELD_W-1:0]  alarm_o,
    output logic                                arm_o,
    output logic                                ctl_en_o,
    output logic                                sts_o,
    output logic [DATA_W-1:0]                   rdata
);
    localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_IEN = ADDR_W'(OFS_IRQ_EN);
    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(OFS_PWR_CTL);

    logic [FIELD_W-1:0] alm_q [NUM_FIELDS];
    logic arm_q, ctl_q, sts_q;
    logic sts_clr;

    for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_field
        localparam logic [ADDR_W-1:0] A_FLD = ADDR_W'(OFS_ALARM_BASE + 4 * gi);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                alm_q[gi] <= '0;
            else if (wr_en && addr == A_FLD)
                alm_q[gi] <= wdata[FIELD_W-1:0];
        end
        assign alarm_o[gi] = alm_q[gi];
    end

    // Arm and pin-control bits change only on full-word writes.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_q <= 1'b0;
            ctl_q <= 1'b0;
        end else begin
            if (wr_en && wr_word && addr == A_IEN) arm_q <= wdata[ARM_BIT];
            if (wr_en && wr_word && addr == A_CTL) ctl_q <= wdata[CTL_BIT];
        end
    end

    // A match event outranks a write-one-to-clear in the same cycle.
    assign sts_clr = wr_en && addr == A_STS && wdata[STS_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       sts_q <= 1'b0;
        else if (evt)     sts_q <= 1'b1;
        else if (sts_clr) sts_q <= 1'b0;
    end

    always_comb begin
        rdata = '0;
        if (addr == A_STS) rdata[STS_BIT] = sts_q;
        if (addr == A_IEN) rdata[ARM_BIT] = arm_q;
        if (addr == A_CTL) rdata[CTL_BIT] = ctl_q;
        for (int i = 0; i < NUM_FIELDS; i++)
            if (addr == ADDR_W'(OFS_ALARM_BASE + 4 * i))
                rdata[FIELD_W-1:0] = alm_q[i];
    end

    logic unused_wdata;
    assign unused_wdata = ^{wdata[DATA_W-1:CTL_BIT+1], wdata[CTL_BIT-1:FIELD_W]};

    assign arm_o    = arm_q;
    assign ctl_en_o = ctl_q;
    assign sts_o    = sts_q;
endmodule

// File: rtl/rtc_pwroff_match.sv
module rtc_pwroff_match
    import rtc_pwroff_pkg::*;
(
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_FIELDS-1:0][FIELD_W-1:0]  now_i,
    input  logic [NUM_FIELDS-1:0][FIELD_W-1:0]  alarm_i,
    input  logic                                arm,
    output logic                                evt
);
    logic [FIELD_W-1:0]    sec_prev;
    logic                  primed;
    logic [NUM_FIELDS-1:0] fld_eq;
    logic                  sec_step;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_prev <= '0;
            primed   <= 1'b0;
        end else begin
            sec_prev <= now_i[0];
            primed   <= 1'b1;
        end
    end

    for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_cmp
        assign fld_eq[gi] = (now_i[gi] == alarm_i[gi]);
    end

    // Evaluate only on the cycle the seconds value moves: one event per match.
    assign sec_step = primed && (now_i[0] != sec_prev);
    assign evt      = sec_step && arm && (&fld_eq);
endmodule

// File: rtl/rtc_pwroff_fsm.sv
module rtc_pwroff_fsm
    import rtc_pwroff_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic ctl_en,
    output logic power_en
);
    pwr_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PWR_ON;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PWR_ON:  if (evt && ctl_en) state_d = PWR_OFF;   // SHUTDOWN
            PWR_OFF: state_d = PWR_OFF;                      // held until reset
        endcase
    end

    always_comb begin
        unique case (state_q)
            PWR_ON:  power_en = 1'b1;
            PWR_OFF: power_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/rtc_pwroff_ctrl.sv
module rtc_pwroff_ctrl
    import rtc_pwroff_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        tm_sec,
    input  logic [7:0]        tm_min,
    input  logic [7:0]        tm_hour,
    input  logic [7:0]        tm_day,
    input  logic [7:0]        tm_mon,
    input  logic [7:0]        tm_year,
    input  logic              reg_wr,
    input  logic              reg_word,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              power_en
);
    logic [NUM_FIELDS-1:0][FIELD_W-1:0] now_bus;
    logic [NUM_FIELDS-1:0][FIELD_W-1:0] alarm_bus;
    logic match_evt, arm, ctl_en, sts_flag;

    assign now_bus = {tm_year, tm_mon, tm_day, tm_hour, tm_min, tm_sec};

    rtc_pwroff_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .wr_word  (reg_word),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .evt      (match_evt),
        .alarm_o  (alarm_bus),
        .arm_o    (arm),
        .ctl_en_o (ctl_en),
        .sts_o    (sts_flag),
        .rdata    (reg_rdata)
    );

    rtc_pwroff_match u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .now_i   (now_bus),
        .alarm_i (alarm_bus),
        .arm     (arm),
        .evt     (match_evt)
    );

    rtc_pwroff_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (match_evt),
        .ctl_en   (ctl_en),
        .power_en (power_en)
    );
endmodule

// File: rtl/rtc_pwroff_chk.sv
module rtc_pwroff_chk (
    input logic clk,
    input logic rst_n,
    input logic power_en,
    input logic evt,
    input logic ctl_en,
    input logic arm,
    input logic sts
);
    // R10: OFF is sticky
    p_off_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !power_en |=> !power_en);

    // R8: shutdown only after an event with pin control enabled
    p_fall_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(power_en) |-> ($past(evt) && $past(ctl_en)));

    // R9: an event without pin control leaves power_en alone
    p_no_ctl_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !ctl_en && power_en) |=> power_en);

    // R5: an event always leaves the status flag set
    p_evt_sets_sts_r5: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> sts);

    // R6: events only while armed
    p_evt_armed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> arm);

    // R5: the flag only rises after an event
    p_sts_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts) |-> $past(evt));
endmodule

bind rtc_pwroff_ctrl rtc_pwroff_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .power_en (power_en),
    .evt      (match_evt),
    .ctl_en   (ctl_en),
    .arm      (arm),
    .sts      (sts_flag)
);

// File: tb/rtc_pwroff_ctrl_tb.sv
module rtc_pwroff_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  tm_sec = 8'h00, tm_min = 8'h30, tm_hour = 8'h12;
    logic [7:0]  tm_day = 8'h15, tm_mon = 8'h06, tm_year = 8'h24;
    logic        reg_wr = 1'b0, reg_word = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        power_en;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_pwroff_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .tm_sec(tm_sec), .tm_min(tm_min), .tm_hour(tm_hour),
        .tm_day(tm_day), .tm_mon(tm_mon), .tm_year(tm_year),
        .reg_wr(reg_wr), .reg_word(reg_word), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .power_en(power_en)
    );

    typedef struct {
        int          kind;    // 0: register read, 1: power_en pin
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Monitor: pops expectations and compares away from the active edge.
    always @(negedge clk) begin
        while (q.size() != 0) begin
            item_t it;
            logic [31:0] got;
            it  = q.pop_front();
            got = (it.kind == 1) ? {31'b0, power_en} : reg_rdata;
            n_vec++;
            if (got !== it.exp) begin
                n_bad++;
                $display("FAIL %s: got 0x%08h expected 0x%08h", it.tag, got, it.exp);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_reg(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        reg_addr = a;
        it.kind = 0; it.exp = e; it.tag = tag;
        q.push_back(it);
        wait (q.size() == 0);
        step(1);
    endtask

    task automatic expect_pin(input logic e, input string tag);
        item_t it;
        it.kind = 1; it.exp = {31'b0, e}; it.tag = tag;
        q.push_back(it);
        wait (q.size() == 0);
        step(1);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic word);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_word = word;
        step(1);
        reg_wr = 1'b0; reg_word = 1'b0;
    endtask

    task automatic set_sec(input logic [7:0] s);
        tm_sec = s;
        step(1);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1: reset state
        expect_pin(1'b1, "R1 power_en after reset");
        expect_reg(8'h44, 32'h0, "R1 status after reset");
        expect_reg(8'h48, 32'h0, "R1 irq enable after reset");
        expect_reg(8'h98, 32'h0, "R1 power ctl after reset");
        expect_reg(8'h94, 32'h0, "R1 alarm year after reset");

        // R2: alarm fields, byte and word writes
        wr(8'h80, 32'hFFFF_FF01, 1'b1);
        expect_reg(8'h80, 32'h0000_0001, "R2 word write seconds");
        wr(8'h84, 32'h0000_0030, 1'b0);
        wr(8'h88, 32'h0000_0012, 1'b0);
        wr(8'h8C, 32'h0000_0015, 1'b1);
        wr(8'h90, 32'h0000_0006, 1'b0);
        wr(8'h94, 32'hABCD_0025, 1'b0);
        expect_reg(8'h94, 32'h0000_0025, "R2 byte write year");
        expect_reg(8'h8C, 32'h0000_0015, "R2 day field");

        // R4: byte write does not arm, word write does
        wr(8'h48, 32'h0000_0010, 1'b0);
        expect_reg(8'h48, 32'h0, "R4 byte write ignored");
        wr(8'h48, 32'h0000_0010, 1'b1);
        expect_reg(8'h48, 32'h0000_0010, "R4 word write arms");

        // R5: year mismatch gives no event
        set_sec(8'h01);
        expect_reg(8'h44, 32'h0, "R5 single field mismatch");

        // R5/R9: full match with pin control clear
        wr(8'h94, 32'h0000_0024, 1'b0);
        wr(8'h80, 32'h0000_0002, 1'b0);
        set_sec(8'h02);
        expect_reg(8'h44, 32'h0000_0080, "R5 match sets status");
        expect_pin(1'b1, "R9 power_en kept without pin control");

        // R7: write-0 keeps, write-1 clears
        wr(8'h44, 32'h0000_0000, 1'b1);
        expect_reg(8'h44, 32'h0000_0080, "R7 write 0 keeps flag");
        wr(8'h44, 32'h0000_0080, 1'b0);
        expect_reg(8'h44, 32'h0, "R7 write 1 clears flag");

        // R6: steady seconds with a matching alarm, and rewrite of same second
        step(4);
        wr(8'h80, 32'h0000_0002, 1'b1);
        step(2);
        expect_reg(8'h44, 32'h0, "R6 no repeat without seconds change");

        // R4/R6: disarmed alarm does not fire
        wr(8'h48, 32'h0, 1'b1);
        expect_reg(8'h48, 32'h0, "R4 word write 0 disarms");
        wr(8'h80, 32'h0000_0003, 1'b0);
        set_sec(8'h03);
        expect_reg(8'h44, 32'h0, "R6 disarmed no event");

        // R3: pin control needs a word write
        wr(8'h98, 32'h0001_0000, 1'b0);
        expect_reg(8'h98, 32'h0, "R3 byte write ignored");
        wr(8'h98, 32'h0001_0000, 1'b1);
        expect_reg(8'h98, 32'h0001_0000, "R3 word write sets bit 16");

        // R7/R8: clear and match in the same cycle
        wr(8'h48, 32'h0000_0010, 1'b1);
        wr(8'h80, 32'h0000_0005, 1'b0);
        expect_pin(1'b1, "R8 power_en before match");
        reg_wr = 1'b1; reg_addr = 8'h44; reg_wdata = 32'h0000_0080; reg_word = 1'b1;
        tm_sec = 8'h05;
        step(1);
        reg_wr = 1'b0; reg_word = 1'b0;
        expect_reg(8'h44, 32'h0000_0080, "R7 set wins over clear");
        expect_pin(1'b0, "R8 power_en off after match");

        // R10: OFF holds through clear, disarm, control clear
        wr(8'h44, 32'h0000_0080, 1'b1);
        wr(8'h48, 32'h0, 1'b1);
        wr(8'h98, 32'h0, 1'b1);
        set_sec(8'h06);
        step(3);
        expect_reg(8'h44, 32'h0, "R10 status cleared");
        expect_pin(1'b0, "R10 power_en stays off");

        // R1/R10: only reset restores ON
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(1);
        expect_pin(1'b1, "R10 reset restores power_en");

        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        #1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule